// File: doc/BRIEF.md
# Two-wire control register slave for a clock generator

This block is the configuration front end of a multi-output clock generator. It sits on a two-wire serial bus as a slave with a fixed 7-bit device address. It holds a small bank of control bytes and presents them as plain outputs to the synthesizer core: a 6-bit frequency selection code, a spread-spectrum enable with a choice of modulation depth, per-output enables, and a per-group high-impedance mask.

A write frame always has the same shape. The address byte comes first. A command byte and a count byte follow, and the slave acknowledges both but does not use their values. Each data byte after that lands in the next register, starting at register 0. A read frame returns the registers from register 0 upward until the master refuses a byte. Only the power-up reset loads the defaults. Neither a STOP nor an aborted frame changes any stored value.

The bus lines are sampled by an oversampling system clock through two-flop synchronizers. SDA is driven open-drain, with `sda_oe_o` high meaning the line is pulled low. SCL is never driven.

Top module: `i2c_ctl_slave`

## Requirements
- R1: The first byte after a START is an address byte. Bits [7:1] hold the address and bit 0 is the direction (0 = write, 1 = read). The slave acknowledges only when bits [7:1] equal `DEV_ADDR`. For any other address it leaves SDA released for the rest of the frame.
- R2: In a write frame, the two bytes that follow the address are acknowledged and their values are discarded. No register output changes because of them.
- R3: Each data byte after the second discarded byte is acknowledged and written to register 0, then 1, then 2, and so on. The new value appears on the outputs at the third rising system-clock edge after `scl_i` rises for the byte's eighth bit.
- R4: Data bytes sent after the last register has been written are acknowledged and discarded.
- R5: Register 0 drives the synthesizer controls: bits [5:0] are `freq_sel_o`, bit 6 is `ss_en_o`, and bit 7 is `ss_wide_o` (1 = 0.75 % centre spread, 0 = 0.5 %). Bit k of register r, for 1 ≤ r ≤ NREG-2, is `clk_en_o[(r-1)*8+k]` (1 = running). Register NREG-1 is `hiz_o` (1 = group in tri-state).
- R6: The power-up reset loads register 0 with 8'h0D, the enable registers with 8'hFF and the last register with 8'h00. A STOP, a repeated START or an aborted frame leaves all registers unchanged.
- R7: In a read frame, the slave returns register 0 first and then the following registers, each byte MSB first. A master ACK requests the next byte and a NACK ends the read. Indices past the last register read as 8'h00.
- R8: The slave changes its SDA drive only while SCL is low.
- R9: A repeated START restarts the frame. The next byte is treated as an address, and data writes or reads start again at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain) |
| freq_sel_o | output | 6 | Frequency combination code |
| ss_en_o | output | 1 | Spread-spectrum enable |
| ss_wide_o | output | 1 | Spread depth: 1 = 0.75 %, 0 = 0.5 % |
| clk_en_o | output | (NREG-2)*8 | Per-output clock enables |
| hiz_o | output | 8 | Per-group tri-state mode |

## Verification
The hardest case is a repeated START issued right after the acknowledge of a data byte. The slave is still releasing its ACK drive inside that SCL low phase, and the same low phase is where the master prepares the SDA fall that restarts the frame. The bench provokes this by re-addressing the slave in the middle of a write, and again by switching from a write to a read. It judges the result by the ACK of the new address byte, by the next data byte landing in register 0 again, and by a read that returns register 0 first. A behavioural model of the register bytes is compared with every output on every clock, so a write that lands one cycle early or late is caught.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_TX,
        ST_MACK,
        ST_TX_LOAD
    } eng_state_e;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_CMD,
        ROLE_CNT,
        ROLE_DATA
    } byte_role_e;

    // power-up value of register idx in a bank of nreg registers
    function automatic logic [7:0] reg_default(input int idx, input int nreg);
        if (idx == 0)
            return 8'h0D;
        else if (idx == nreg - 1)
            return 8'h00;
        else
            return 8'hFF;
    endfunction

    function automatic byte_role_e next_role(input byte_role_e r);
        case (r)
            ROLE_ADDR: return ROLE_CMD;
            ROLE_CMD:  return ROLE_CNT;
            default:   return ROLE_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_ctl_sync.sv
module i2c_ctl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] prev_o
);
    // STAGES synchronizing flops plus one history flop for edge detection
    typedef logic [STAGES:0][W-1:0] pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            pipe_q <= '1;
        else
            pipe_q <= pipe_d;
    end

    assign q_o    = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/i2c_ctl_engine.sv
module i2c_ctl_engine
    import i2c_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter int         NREG     = 4,
    parameter int         IDXW     = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            scl_s,
    input  logic            scl_p,
    input  logic            sda_s,
    input  logic            sda_p,
    input  logic [7:0]      rd_data_i,
    output logic            wr_en_o,
    output logic [IDXW-1:0] idx_o,
    output logic [7:0]      wr_data_o,
    output logic            sda_oe_o
);

    typedef struct packed {
        eng_state_e      st;
        byte_role_e      role;
        logic [2:0]      bitcnt;
        logic [7:0]      shreg;
        logic [IDXW-1:0] idx;
        logic            rnw;
        logic            sda_oe;
    } eng_t;

    eng_t eng_d, eng_q;

    logic       scl_rise, scl_fall, start_det, stop_det, past_last;
    logic [7:0] rx_byte;

    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
        rx_byte   = {eng_q.shreg[6:0], sda_s};
        past_last = (eng_q.idx == IDXW'(NREG));
        wr_en_o   = 1'b0;
        eng_d     = eng_q;

        if (start_det) begin
            eng_d.st     = ST_RX;
            eng_d.role   = ROLE_ADDR;
            eng_d.bitcnt = 3'd0;
            eng_d.sda_oe = 1'b0;
        end else if (stop_det) begin
            eng_d.st     = ST_IDLE;
            eng_d.sda_oe = 1'b0;
        end else begin
            case (eng_q.st)
                ST_RX: if (scl_rise) begin
                    eng_d.shreg  = rx_byte;
                    eng_d.bitcnt = eng_q.bitcnt + 3'd1;
                    if (eng_q.bitcnt == 3'd7) begin
                        eng_d.st = ST_ACK_WAIT;
                        case (eng_q.role)
                            ROLE_ADDR: begin
                                eng_d.rnw = rx_byte[0];
                                eng_d.idx = '0;
                                if (rx_byte[7:1] != DEV_ADDR)
                                    eng_d.st = ST_IDLE;
                            end
                            ROLE_DATA: if (!past_last) begin
                                wr_en_o   = 1'b1;
                                eng_d.idx = eng_q.idx + IDXW'(1);
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    eng_d.sda_oe = 1'b1;
                    eng_d.st     = ST_ACK_DRIVE;
                end
                ST_ACK_DRIVE: if (scl_fall) begin
                    eng_d.bitcnt = 3'd0;
                    if (eng_q.role == ROLE_ADDR && eng_q.rnw) begin
                        eng_d.shreg  = rd_data_i;
                        eng_d.sda_oe = ~rd_data_i[7];
                        eng_d.st     = ST_TX;
                    end else begin
                        eng_d.sda_oe = 1'b0;
                        eng_d.role   = next_role(eng_q.role);
                        eng_d.st     = ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (eng_q.bitcnt == 3'd7) begin
                        eng_d.sda_oe = 1'b0;
                        eng_d.st     = ST_MACK;
                    end else begin
                        eng_d.sda_oe = ~eng_q.shreg[6];
                        eng_d.shreg  = {eng_q.shreg[6:0], 1'b0};
                        eng_d.bitcnt = eng_q.bitcnt + 3'd1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    if (sda_s) begin
                        eng_d.st = ST_IDLE;
                    end else begin
                        eng_d.st = ST_TX_LOAD;
                        if (!past_last)
                            eng_d.idx = eng_q.idx + IDXW'(1);
                    end
                end
                ST_TX_LOAD: if (scl_fall) begin
                    eng_d.shreg  = rd_data_i;
                    eng_d.sda_oe = ~rd_data_i[7];
                    eng_d.bitcnt = 3'd0;
                    eng_d.st     = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q.st     <= ST_IDLE;
            eng_q.role   <= ROLE_ADDR;
            eng_q.bitcnt <= '0;
            eng_q.shreg  <= '0;
            eng_q.idx    <= '0;
            eng_q.rnw    <= 1'b0;
            eng_q.sda_oe <= 1'b0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign idx_o     = eng_q.idx;
    assign wr_data_o = rx_byte;
    assign sda_oe_o  = eng_q.sda_oe;

endmodule

// File: rtl/i2c_ctl_bank.sv
module i2c_ctl_bank
    import i2c_ctl_pkg::*;
#(
    parameter int NREG = 4,
    parameter int IDXW = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDXW-1:0]   idx_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o,
    output logic [NREG*8-1:0] regs_o
);

    logic [NREG-1:0][7:0] regs_d, regs_q;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign regs_d[r] = (wr_en_i && idx_i == IDXW'(r)) ? wr_data_i : regs_q[r];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int r = 0; r < NREG; r++)
                regs_q[r] <= reg_default(r, NREG);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int r = 0; r < NREG; r++)
            if (idx_i == IDXW'(r))
                rd_data_o = regs_q[r];
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
    import i2c_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter int         NREG     = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [5:0]            freq_sel_o,
    output logic                  ss_en_o,
    output logic                  ss_wide_o,
    output logic [(NREG-2)*8-1:0] clk_en_o,
    output logic [7:0]            hiz_o
);

    localparam int IDXW = $clog2(NREG + 1);

    logic [1:0]        line_s, line_p;
    logic              wr_en;
    logic [IDXW-1:0]   reg_idx;
    logic [7:0]        wr_data, rd_data;
    logic [NREG*8-1:0] regs_flat;

    i2c_ctl_sync #(.W(2), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({scl_i, sda_i}),
        .q_o    (line_s),
        .prev_o (line_p)
    );

    i2c_ctl_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .IDXW(IDXW)) u_engine (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_s     (line_s[1]),
        .scl_p     (line_p[1]),
        .sda_s     (line_s[0]),
        .sda_p     (line_p[0]),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .idx_o     (reg_idx),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    i2c_ctl_bank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .idx_i     (reg_idx),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .regs_o    (regs_flat)
    );

    assign freq_sel_o = regs_flat[5:0];
    assign ss_en_o    = regs_flat[6];
    assign ss_wide_o  = regs_flat[7];
    assign clk_en_o   = regs_flat[(NREG-1)*8-1:8];
    assign hiz_o      = regs_flat[NREG*8-1:(NREG-1)*8];

endmodule

// File: rtl/i2c_ctl_chk.sv
module i2c_ctl_chk #(
    parameter int NREG = 4,
    parameter int IDXW = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic              wr_en,
    input logic [IDXW-1:0]   reg_idx,
    input logic [NREG*8-1:0] regs_flat
);

    // R8: SDA drive only moves while the bus clock is low
    a_r8_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sda_oe_o) |-> !scl_i);

    // R6: stored bytes change only through a write strobe
    a_r6_regs_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en |=> $stable(regs_flat));

    // R4: a write strobe never targets an index beyond the bank
    a_r4_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |-> (reg_idx < IDXW'(NREG)));

    // R3: a register is never written while the slave is driving the bus
    a_r3_no_write_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |-> !sda_oe_o);

endmodule

bind i2c_ctl_slave i2c_ctl_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en     (wr_en),
    .reg_idx   (reg_idx),
    .regs_flat (regs_flat)
);

// File: tb/i2c_ctl_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_ctl_slave_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         NREG       = 4;
    localparam int         ENW        = (NREG - 2) * 8;
    localparam logic [6:0] ADDR       = 7'b1101001;
    localparam int         QTR        = 4;
    localparam int         WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [5:0] freq_sel;
    logic ss_en, ss_wide;
    logic [ENW-1:0] clk_en;
    logic [7:0] hiz;

    int n_tests = 0;
    int n_fail  = 0;
    int n_shown = 0;
    bit done    = 1'b0;

    logic [7:0] exp_regs [NREG];
    logic [7:0] rd_q [$];

    assign sda_bus = ~(m_sda_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ctl_slave #(.DEV_ADDR(ADDR), .NREG(NREG)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .freq_sel_o (freq_sel),
        .ss_en_o    (ss_en),
        .ss_wide_o  (ss_wide),
        .clk_en_o   (clk_en),
        .hiz_o      (hiz)
    );

    function automatic logic [ENW-1:0] model_en();
        logic [ENW-1:0] v;
        for (int r = 1; r <= NREG - 2; r++)
            v[(r-1)*8 +: 8] = exp_regs[r];
        return v;
    endfunction

    // every-cycle comparison of all register outputs against the model (R3, R5, R6)
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            n_tests++;
            if (freq_sel !== exp_regs[0][5:0] || ss_en !== exp_regs[0][6] ||
                ss_wide !== exp_regs[0][7] || clk_en !== model_en() ||
                hiz !== exp_regs[NREG-1]) begin
                n_fail++;
                if (n_shown < 10) begin
                    n_shown++;
                    $display("FAIL R3/R5/R6 outputs at %0t: got %h_%b_%b_%h_%h expected %h_%b_%b_%h_%h",
                             $time, freq_sel, ss_en, ss_wide, clk_en, hiz,
                             exp_regs[0][5:0], exp_regs[0][6], exp_regs[0][7],
                             model_en(), exp_regs[NREG-1]);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_q();
        m_scl = 1'b1;     wait_q();
        m_sda_low = 1'b1; wait_q();
        m_scl = 1'b0;     wait_q();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_q();
        m_scl = 1'b1;     wait_q();
        m_sda_low = 1'b0; wait_q();
        wait_q();
    endtask

    // widx >= 0: the model stores b into that register when it commits
    task automatic send_byte(input logic [7:0] b, input int widx, input bit exp_ack, input string req);
        bit got;
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i];
            wait_q();
            m_scl = 1'b1;
            if (i == 0) begin
                repeat (2) @(negedge clk);
                if (widx >= 0 && widx < NREG)
                    exp_regs[widx] = b;
                repeat (QTR - 2) @(negedge clk);
            end else begin
                wait_q();
            end
            m_scl = 1'b0;
            wait_q();
        end
        m_sda_low = 1'b0;
        wait_q();
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        got = !sda_bus;
        repeat (QTR - 2) @(negedge clk);
        m_scl = 1'b0;
        wait_q();
        check(got == exp_ack, req, int'(got), int'(exp_ack));
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit master_ack);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            m_scl = 1'b1;
            repeat (2) @(negedge clk);
            b[i] = sda_bus;
            repeat (QTR - 2) @(negedge clk);
            m_scl = 1'b0;
        end
        m_sda_low = master_ack;
        wait_q();
        m_scl = 1'b1;
        wait_q();
        m_scl = 1'b0;
        m_sda_low = 1'b0;
        wait_q();
    endtask

    task automatic read_frame(input int count, input string req);
        logic [7:0] got;
        rd_q = {};
        for (int i = 0; i < count; i++)
            rd_q.push_back(i < NREG ? exp_regs[i] : 8'h00);
        for (int i = 0; i < count; i++) begin
            recv_byte(got, i != count - 1);
            check(got == rd_q[i], req, int'(got), int'(rd_q[i]));
        end
    endtask

    initial begin
        for (int r = 0; r < NREG; r++)
            exp_regs[r] = (r == 0) ? 8'h0D : ((r == NREG - 1) ? 8'h00 : 8'hFF);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6: power-up values on the outputs
        check(freq_sel == 6'h0D && !ss_en && !ss_wide, "R6 reset reg0", int'({ss_wide, ss_en, freq_sel}), 8'h0D);
        check(clk_en == '1 && hiz == 8'h00, "R6 reset enables/hiz", int'(hiz), 0);
        check(sda_oe == 1'b0, "R6 reset sda released", int'(sda_oe), 0);

        // R1, R2, R3, R4, R5: full write frame with overflow bytes
        bus_start();
        send_byte({ADDR, 1'b0}, -1, 1'b1, "R1 address ack");
        send_byte(8'hA5, -1, 1'b1, "R2 command byte ack");
        send_byte(8'h03, -1, 1'b1, "R2 count byte ack");
        send_byte(8'hEA, 0, 1'b1, "R3 data0 ack");
        send_byte(8'h0F, 1, 1'b1, "R3 data1 ack");
        send_byte(8'hF0, 2, 1'b1, "R3 data2 ack");
        send_byte(8'h81, 3, 1'b1, "R3 data3 ack");
        send_byte(8'h77, 4, 1'b1, "R4 overflow byte ack");
        send_byte(8'h55, 5, 1'b1, "R4 second overflow ack");
        bus_stop();
        check(freq_sel == 6'h2A && ss_en && ss_wide, "R5 reg0 fields", int'({ss_wide, ss_en, freq_sel}), 8'hEA);
        check(clk_en == 16'hF00F, "R5 enable mapping", int'(clk_en), 16'hF00F);

        // R1: foreign address is never acknowledged
        bus_start();
        send_byte(8'h44, -1, 1'b0, "R1 foreign address nack");
        send_byte(8'h00, -1, 1'b0, "R1 foreign frame stays silent");
        bus_stop();

        // R7: read back from register 0, running past the end
        bus_start();
        send_byte({ADDR, 1'b1}, -1, 1'b1, "R7 read address ack");
        read_frame(NREG + 1, "R7 read data");
        bus_stop();
        check(sda_oe == 1'b0, "R7 released after nack", int'(sda_oe), 0);

        // R9: repeated START in the middle of a write restarts at register 0
        bus_start();
        send_byte({ADDR, 1'b0}, -1, 1'b1, "R9 first address ack");
        send_byte(8'h00, -1, 1'b1, "R2 command ack");
        send_byte(8'hFF, -1, 1'b1, "R2 count ack");
        send_byte(8'h11, 0, 1'b1, "R9 data before restart");
        bus_start();
        send_byte({ADDR, 1'b0}, -1, 1'b1, "R9 restarted address ack");
        send_byte(8'h12, -1, 1'b1, "R2 command ack");
        send_byte(8'h34, -1, 1'b1, "R2 count ack");
        send_byte(8'h3F, 0, 1'b1, "R9 data lands in reg0");
        send_byte(8'hC3, 1, 1'b1, "R9 data lands in reg1");
        bus_stop();

        // R6, R2: aborted frame leaves everything as it was
        bus_start();
        send_byte({ADDR, 1'b0}, -1, 1'b1, "R6 abort address ack");
        send_byte(8'h99, -1, 1'b1, "R6 abort command ack");
        bus_stop();
        check(freq_sel == 6'h3F && clk_en[7:0] == 8'hC3, "R6 no change after abort", int'(freq_sel), 8'h3F);

        // R9, R7: write header then repeated START into a read
        bus_start();
        send_byte({ADDR, 1'b0}, -1, 1'b1, "R9 write header ack");
        send_byte(8'h01, -1, 1'b1, "R2 command ack");
        bus_start();
        send_byte({ADDR, 1'b1}, -1, 1'b1, "R9 read after restart ack");
        read_frame(2, "R9 read from reg0");
        bus_stop();

        repeat (8) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule